// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits between a set of interrupting devices and a CPU. It takes a number of level-sensitive maskable request lines and one non-maskable line, ranks them by fixed priority, and raises one interrupt request toward the CPU. It keeps that request up until the CPU acknowledges. On the acknowledge it picks the highest-priority eligible source. It sends a one-cycle acknowledge pulse to that source and puts the source's vector on the vector bus, where the CPU uses it to index its handler table.

The controller keeps a stack of the priority levels in service. While a level is in service, requests of that priority or lower are held off. A higher-priority request raises the CPU request again, so handlers can nest. An end-of-service pulse from the CPU pops the innermost level and brings back the mask of the level beneath it. The non-maskable line outranks every maskable line and ignores their levels. The only thing that holds it off is its own service.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset the in-service stack is empty. `cpu_irq`, `vec_valid`, `vec` and all acknowledge outputs are low while no request input is active.
- R2: `cpu_irq` is high in every cycle in which at least one eligible request is active, and low otherwise. It therefore stays high until an acknowledge, unless the request is withdrawn.
- R3: Priority is fixed. The non-maskable line ranks highest, then line 0, then line 1, and so on. An acknowledge selects the highest-ranked eligible request.
- R4: In the cycle after the clock edge that samples `cpu_ack` high while `cpu_irq` is high, `vec_valid` is high for exactly one cycle. `vec` then carries i for line i and NUM_LINES for the non-maskable line. `vec` is zero whenever `vec_valid` is low.
- R5: In that same cycle exactly one acknowledge output pulses: `dev_ack[i]` for line i or `nmi_ack` for the non-maskable line.
- R6: While a maskable line i is the innermost level in service, lines i to NUM_LINES-1 are not eligible.
- R7: A request ranked higher than the innermost level in service raises `cpu_irq`, and acknowledging it nests a new level on top.
- R8: An `eoi` pulse removes the innermost level and restores the mask of the level below it. An `eoi` with nothing in service has no effect.
- R9: The non-maskable request is eligible whatever maskable level is in service. It is held off only while a non-maskable service is itself the innermost level.
- R10: A request withdrawn before the acknowledge edge is discarded. That acknowledge yields no vector and no acknowledge pulse, and it leaves the in-service stack unchanged.
- R11: A `cpu_ack` sampled while `cpu_irq` is low is ignored.
- R12: When `eoi` and an accepted acknowledge share a clock edge, the winner is chosen with the mask from before the edge. The innermost level is removed first and the winner is then placed on top.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_line | input | NUM_LINES | Level-sensitive maskable requests; bit 0 ranks highest |
| nmi_req | input | 1 | Level-sensitive non-maskable request |
| cpu_ack | input | 1 | Interrupt acknowledge from the CPU, sampled at the clock edge |
| eoi | input | 1 | End-of-service pulse from the CPU |
| cpu_irq | output | 1 | Interrupt request to the CPU |
| vec_valid | output | 1 | Vector strobe, one cycle after an accepted acknowledge |
| vec | output | $clog2(NUM_LINES+1) | Vector of the acknowledged source |
| dev_ack | output | NUM_LINES | One-cycle acknowledge to the winning maskable line |
| nmi_ack | output | 1 | One-cycle acknowledge to the non-maskable source |

## Verification
The bench builds the controller with NUM_LINES set to 4. With that setting a short run can nest every level, including the non-maskable one on top of line 0. It can also exercise masking of equal and lower lines, and vector NUM_LINES shows up on a narrow bus. A queue-based reference model of the in-service levels predicts the request line, the vector and the acknowledge pulses every cycle. Directed sequences cover withdrawn requests, stray acknowledges, an `eoi` on an empty stack, and `eoi` coinciding with an acknowledge.

// File: rtl/intc_pkg.sv
package intc_pkg;

   // Width of an internal priority rank: ranks 0..NUM_LINES plus an idle code.
   function automatic int rank_w(input int lines);
      return $clog2(lines + 2);
   endfunction

   // Width of the vector bus.
   function automatic int vec_w(input int lines);
      return $clog2(lines + 1);
   endfunction

   // Rank 0 is the non-maskable source (vector = lines); rank k is line k-1.
   function automatic int rank_to_vec(input int rank, input int lines);
      return (rank == 0) ? lines : rank - 1;
   endfunction

endpackage

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
   parameter int NUM_LINES = 8,
   parameter int RW        = intc_pkg::rank_w(NUM_LINES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES:0]   req,     // bit 0: non-maskable, bit k: line k-1
   input  logic [RW-1:0]        top,     // innermost rank in service, IDLE if none
   output logic [NUM_LINES:0]   elig,
   output logic                 any,
   output logic [RW-1:0]        win
);
   localparam logic [RW-1:0] IDLE = RW'(NUM_LINES + 1);

   for (genvar k = 0; k <= NUM_LINES; k++) begin : g_elig
      if (k == 0) begin : g_nmi
         assign elig[k] = req[k] && (top != '0);
      end else begin : g_mask
         assign elig[k] = req[k] && (RW'(k) < top);
      end
   end

   always_comb begin
      win = IDLE;
      for (int k = NUM_LINES; k >= 0; k--) begin
         if (elig[k]) win = RW'(k);
      end
   end

   assign any = |elig;

   p_win_eligible_r3: assert property (@(posedge clk) disable iff (!rst_n)
      any |-> (win <= RW'(NUM_LINES)) && req[win]);

   p_nmi_unmasked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req[0] && top != '0) |-> (any && win == '0));

   p_masked_equal_r6: assert property (@(posedge clk) disable iff (!rst_n)
      any |-> (win < top));
endmodule

// File: rtl/intc_svc_stack.sv
module intc_svc_stack #(
   parameter int NUM_LINES = 8,
   parameter int RW        = intc_pkg::rank_w(NUM_LINES),
   parameter int DEPTH     = NUM_LINES + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          pop,
   input  logic [RW-1:0] push_rank,
   output logic [RW-1:0] top
);
   localparam logic [RW-1:0] IDLE = RW'(NUM_LINES + 1);

   logic [DEPTH-1:0][RW-1:0] stk;
   logic [DEPTH-1:0][RW-1:0] shift_dn;
   logic [DEPTH-1:0][RW-1:0] shift_up;

   for (genvar j = 0; j < DEPTH; j++) begin : g_nb
      if (j == 0) begin : g_head
         assign shift_dn[j] = push_rank;
      end else begin : g_body
         assign shift_dn[j] = stk[j-1];
      end
      if (j == DEPTH - 1) begin : g_tail
         assign shift_up[j] = IDLE;
      end else begin : g_rest
         assign shift_up[j] = stk[j+1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int j = 0; j < DEPTH; j++) stk[j] <= IDLE;
      end else if (push && pop) begin
         stk[0] <= push_rank;
      end else if (push) begin
         stk <= shift_dn;
      end else if (pop) begin
         stk <= shift_up;
      end
   end

   assign top = stk[0];

   for (genvar j = 0; j < DEPTH - 1; j++) begin : g_chk
      p_nest_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (stk[j+1] != IDLE) |-> (stk[j] < stk[j+1]));
   end

   p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop) |-> (stk[DEPTH-1] == IDLE));

   p_empty_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && top == IDLE) |=> (top == IDLE));
endmodule

// File: rtl/intc_ack_out.sv
module intc_ack_out #(
   parameter int NUM_LINES = 8,
   parameter int RW        = intc_pkg::rank_w(NUM_LINES),
   parameter int VW        = intc_pkg::vec_w(NUM_LINES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               take,
   input  logic [RW-1:0]      win,
   output logic               vec_valid,
   output logic [VW-1:0]      vec,
   output logic [NUM_LINES:0] src_ack
);
   logic [VW-1:0]      vec_nxt;
   logic [NUM_LINES:0] ack_nxt;

   always_comb begin
      vec_nxt = '0;
      ack_nxt = '0;
      for (int k = 0; k <= NUM_LINES; k++) begin
         if (take && win == RW'(k)) begin
            vec_nxt    = VW'(intc_pkg::rank_to_vec(k, NUM_LINES));
            ack_nxt[k] = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_valid <= 1'b0;
         vec       <= '0;
         src_ack   <= '0;
      end else begin
         vec_valid <= take;
         vec       <= vec_nxt;
         src_ack   <= ack_nxt;
      end
   end

   p_ack_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(src_ack));

   p_ack_with_vec_r5: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid == (src_ack != '0));

   p_vec_zero_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !vec_valid |-> (vec == '0));
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc #(
   parameter int NUM_LINES = 8,
   localparam int RW       = intc_pkg::rank_w(NUM_LINES),
   localparam int VW       = intc_pkg::vec_w(NUM_LINES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_line,
   input  logic                 nmi_req,
   input  logic                 cpu_ack,
   input  logic                 eoi,
   output logic                 cpu_irq,
   output logic                 vec_valid,
   output logic [VW-1:0]        vec,
   output logic [NUM_LINES-1:0] dev_ack,
   output logic                 nmi_ack
);
   localparam logic [RW-1:0] IDLE = RW'(NUM_LINES + 1);

   if (NUM_LINES < 1 || NUM_LINES > 64) begin : g_bad_lines
      $error("prio_vec_intc: NUM_LINES must lie in 1..64");
   end

   logic [NUM_LINES:0] req_all;
   logic [NUM_LINES:0] elig;
   logic [NUM_LINES:0] src_ack;
   logic [RW-1:0]      top;
   logic [RW-1:0]      win;
   logic               any;
   logic               take;
   logic               pop;

   assign req_all = {irq_line, nmi_req};
   assign take    = cpu_ack && any;
   assign pop     = eoi && (top != IDLE);

   intc_arbiter #(.NUM_LINES(NUM_LINES), .RW(RW)) i_arb (
      .clk(clk), .rst_n(rst_n), .req(req_all), .top(top),
      .elig(elig), .any(any), .win(win)
   );

   intc_svc_stack #(.NUM_LINES(NUM_LINES), .RW(RW)) i_stack (
      .clk(clk), .rst_n(rst_n), .push(take), .pop(pop),
      .push_rank(win), .top(top)
   );

   intc_ack_out #(.NUM_LINES(NUM_LINES), .RW(RW), .VW(VW)) i_out (
      .clk(clk), .rst_n(rst_n), .take(take), .win(win),
      .vec_valid(vec_valid), .vec(vec), .src_ack(src_ack)
   );

   assign cpu_irq = any;
   assign nmi_ack = src_ack[0];
   assign dev_ack = src_ack[NUM_LINES:1];

   p_vec_after_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> $past(cpu_ack && cpu_irq));

   p_stray_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ack && !cpu_irq) |=> !vec_valid);

   p_nmi_raises_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (nmi_req && !(top == '0)) |-> cpu_irq);

   p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_line == '0 && !nmi_req) |-> !cpu_irq);
endmodule

// File: tb/test_prio_vec_intc.sv
`timescale 1ns/1ps
module test_prio_vec_intc;
   localparam int N  = 4;
   localparam int VW = $clog2(N + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  irq_line = '0;
   logic          nmi_req = 1'b0;
   logic          cpu_ack = 1'b0;
   logic          eoi = 1'b0;
   logic          cpu_irq;
   logic          vec_valid;
   logic [VW-1:0] vec;
   logic [N-1:0]  dev_ack;
   logic          nmi_ack;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #2 clk = ~clk;

   prio_vec_intc #(.NUM_LINES(N)) i_prio_vec_intc (
      .clk(clk), .rst_n(rst_n), .irq_line(irq_line), .nmi_req(nmi_req),
      .cpu_ack(cpu_ack), .eoi(eoi), .cpu_irq(cpu_irq), .vec_valid(vec_valid),
      .vec(vec), .dev_ack(dev_ack), .nmi_ack(nmi_ack)
   );

   // Reference model: queue of in-service ranks, front is innermost.
   // Rank 0 = non-maskable, rank r = line r-1.
   int svc_q[$];
   int e_vv  = 0;
   int e_vec = 0;
   int e_ack = 0;   // bit 0 non-maskable, bit r line r-1

   function automatic int model_winner();
      int lvl = (svc_q.size() > 0) ? svc_q[0] : N + 1;
      for (int r = 0; r <= N; r++) begin
         bit active = (r == 0) ? nmi_req : irq_line[r-1];
         if (r == 0) begin
            if (active && lvl != 0) return 0;
         end else if (active && r < lvl) begin
            return r;
         end
      end
      return -1;
   endfunction

   always @(posedge clk) begin : mdl
      int w;
      if (!rst_n) begin
         svc_q.delete();
         e_vv = 0; e_vec = 0; e_ack = 0;
      end else begin
         w = model_winner();
         e_vv = 0; e_vec = 0; e_ack = 0;
         if (cpu_ack && w >= 0) begin
            e_vv  = 1;
            e_vec = (w == 0) ? N : w - 1;
            e_ack = 1 << w;
         end
         if (eoi && svc_q.size() > 0) void'(svc_q.pop_front());
         if (cpu_ack && w >= 0) svc_q.push_front(w);
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // Cycle-by-cycle comparison against the model.
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R2 cpu_irq", int'(cpu_irq), int'(model_winner() >= 0));
         chk("R4 vec_valid", int'(vec_valid), e_vv);
         chk("R4 vec", int'(vec), e_vec);
         chk("R5 acks", int'({dev_ack, nmi_ack}), e_ack);
      end
   end

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic do_ack();
      cpu_ack = 1'b1; step(); cpu_ack = 1'b0;
   endtask

   task automatic do_eoi();
      eoi = 1'b1; step(); eoi = 1'b0;
   endtask

   task automatic finish_run();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      #(200000 * 4);
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      step(); step();
      // R1: reset state
      chk("R1 cpu_irq", int'(cpu_irq), 0);
      chk("R1 vec_valid", int'(vec_valid), 0);
      chk("R1 acks", int'({dev_ack, nmi_ack}), 0);
      rst_n = 1'b1;
      step();

      // R2: request held until acknowledge
      irq_line = 4'b0100;
      step(); step(); step();
      chk("R2 held", int'(cpu_irq), 1);
      do_ack();
      chk("R4 valid", int'(vec_valid), 1);
      chk("R4 vector line2", int'(vec), 2);
      chk("R5 dev_ack", int'(dev_ack), 4'b0100);
      step();
      chk("R4 one cycle", int'(vec_valid), 0);
      chk("R6 equal masked", int'(cpu_irq), 0);

      // R6: lower line masked while line 2 in service
      irq_line = 4'b1100;
      step();
      chk("R6 lower masked", int'(cpu_irq), 0);

      // R7: higher line nests
      irq_line = 4'b1110;
      step();
      chk("R7 reraise", int'(cpu_irq), 1);
      do_ack();
      chk("R3 highest eligible", int'(vec), 1);
      irq_line = 4'b1100;
      step();

      // R8: eoi restores previous level
      do_eoi();
      chk("R8 restore mask", int'(cpu_irq), 0);
      do_eoi();
      chk("R8 empty stack", int'(cpu_irq), 1);
      do_ack();
      chk("R3 line2 over line3", int'(vec), 2);
      irq_line = '0;
      do_eoi();
      step();

      // R9: NMI over line 0, then held while itself in service
      irq_line = 4'b0001;
      step();
      do_ack();
      chk("R3 line0 vector", int'(vec), 0);
      nmi_req = 1'b1;
      step();
      chk("R9 nmi unmasked", int'(cpu_irq), 1);
      do_ack();
      chk("R9 nmi vector", int'(vec), N);
      chk("R5 nmi_ack", int'(nmi_ack), 1);
      step();
      chk("R9 nmi self held", int'(cpu_irq), 0);
      nmi_req = 1'b0;
      irq_line = '0;
      do_eoi();
      do_eoi();

      // R8: eoi on empty stack has no effect
      do_eoi();
      irq_line = 4'b1000;
      step();
      chk("R8 empty eoi ignored", int'(cpu_irq), 1);
      do_ack();
      chk("R8 vector line3", int'(vec), 3);
      irq_line = '0;
      do_eoi();

      // R10: request withdrawn before acknowledge
      irq_line = 4'b0010;
      step();
      chk("R10 pending", int'(cpu_irq), 1);
      irq_line = '0;
      do_ack();
      chk("R10 no vector", int'(vec_valid), 0);
      chk("R10 no ack", int'({dev_ack, nmi_ack}), 0);
      irq_line = 4'b1000;
      step();
      chk("R10 stack unchanged", int'(cpu_irq), 1);
      irq_line = '0;
      step();

      // R11: stray acknowledge
      do_ack();
      chk("R11 ignored", int'(vec_valid), 0);
      irq_line = 4'b1000;
      step();
      chk("R11 stack unchanged", int'(cpu_irq), 1);
      irq_line = '0;
      step();

      // R12: eoi together with acknowledge
      irq_line = 4'b0100;
      step();
      do_ack();
      irq_line = 4'b0010;
      step();
      cpu_ack = 1'b1; eoi = 1'b1;
      step();
      cpu_ack = 1'b0; eoi = 1'b0;
      chk("R12 vector", int'(vec), 1);
      irq_line = 4'b0100;
      step();
      chk("R12 line2 popped, line1 on top", int'(cpu_irq), 0);
      do_eoi();
      chk("R12 empty after eoi", int'(cpu_irq), 1);
      irq_line = '0;
      step(); step();

      finish_run();
   end
endmodule